// File: doc/BRIEF.md
# Paged Serial Flash Geometry Detector

This block sits between a controller and a paged SPI serial flash whose page length is 264, 528 or 1056 bytes depending on the part. After reset it reads the device status byte over SPI and takes the density field from it. From that field it picks the page length. It polls again while the device reports busy. Once the geometry is known it raises `ready` and reports the density code and the page length in bytes.

A client then asks for reads by giving a page number and a byte offset inside that page. The block checks the offset against the detected page length. If the offset fits, it packs the read opcode and a 24-bit address into a 32-bit header, using the bit layout for that page length, and shifts the header out in SPI mode 0 with the most significant bit first. Chip select stays low for the whole header and goes high when the header ends. If the offset does not fit, the request ends at once with an error flag and no bus traffic. The array data that follows the header is handled elsewhere.

Top module: `flash_geom_probe`

## Requirements
- R1: Under reset `busy` is 1 and `ready`, `done`, `spi_sck` are 0 with `spi_cs_n` at 1. After reset the block sends a 16-clock frame whose first byte, MSB first, is the status opcode 0xD7, then reads one status byte on `spi_miso`.
- R2: The density code is bits [5:3] of the status byte. For example 0x9C gives 3, 0xA4 gives 4, 0xAC gives 5, 0xB4 gives 6 and 0xBC gives 7. It is shown on `density` once `ready` is 1.
- R3: `page_bytes` is 264 for density codes 0 to 4, 528 for codes 5 and 6, and 1056 for code 7.
- R4: A status byte with bit 7 at 0 means the device is busy. The status frame is then repeated, and `ready` stays 0, until a status byte with bit 7 at 1 arrives.
- R5: Once `ready` is 1 it stays 1, and `density` and `page_bytes` stay constant until the next reset.
- R6: When `ready` is 1 and `busy` is 0, a `req_start` pulse with `req_byte` below `page_bytes` starts one 32-clock frame: read opcode 0xD2, then a 24-bit address, MSB first. `busy` is 1 from the next cycle. At the end `done` pulses for one cycle with `err` at 0.
- R7: For 264-byte pages the address is `req_page * 512 + req_byte`. This places the page number at address bit 9 and up.
- R8: For 528-byte pages the address is `req_page * 1024 + req_byte`.
- R9: For 1056-byte pages the three address bytes are req_page[12:5], then {req_page[4:0], req_byte[10:8]}, then req_byte[7:0].
- R10: A request with `req_byte` at or above `page_bytes` does not drive `spi_cs_n` low. Instead `done` and `err` pulse together for one cycle.
- R11: A `req_start` while `ready` is 0 is dropped. It yields no read frame and no `done`.
- R12: `spi_sck` is low whenever `spi_cs_n` is high, and `spi_cs_n` goes high between any two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | One-cycle read request strobe |
| req_page | input | 13 | Requested page number |
| req_byte | input | 11 | Byte offset within the page |
| busy | output | 1 | Detection or a header transfer in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Valid with `done`: offset was out of range |
| ready | output | 1 | Geometry detected |
| page_bytes | output | 11 | Detected page length in bytes |
| density | output | 3 | Detected density code |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The hardest case to reach from the ports is the busy-poll loop. It needs a flash that answers several status reads with bit 7 clear before it reports ready. It also needs a read request to arrive during that window, and that request must leave no trace. The bench flash model answers a set number of status frames with the ready bit masked off. It pulses a request right after reset. It then counts frames, frame lengths and `done` pulses, and confirms that only 16-clock status frames went out before `ready`.

// File: rtl/fgp_pkg.sv
package fgp_pkg;

   typedef enum logic [1:0] {
      PG_SMALL = 2'd0,
      PG_MID   = 2'd1,
      PG_LARGE = 2'd2
   } pg_kind_e;

   typedef enum logic [2:0] {
      S_PROBE      = 3'd0,
      S_PROBE_WAIT = 3'd1,
      S_IDLE       = 3'd2,
      S_HDR        = 3'd3,
      S_HDR_WAIT   = 3'd4
   } probe_state_e;

endpackage

// File: rtl/fgp_density.sv
module fgp_density
   import fgp_pkg::*;
#(
   parameter int CODE_W   = 3,
   parameter int MID_CODE = 5,
   parameter int TOP_CODE = 7
) (
   input  logic [CODE_W-1:0] code,
   output pg_kind_e          kind
);

   localparam int CODE_MAX = (1 << CODE_W) - 1;

   initial begin
      assert (MID_CODE < TOP_CODE && TOP_CODE <= CODE_MAX)
         else $error("fgp_density: thresholds out of range");
   end

   always_comb begin
      if (int'(code) < MID_CODE)
         kind = PG_SMALL;
      else if (int'(code) < TOP_CODE)
         kind = PG_MID;
      else
         kind = PG_LARGE;
   end

endmodule

// File: rtl/fgp_hdr_pack.sv
module fgp_hdr_pack
   import fgp_pkg::*;
#(
   parameter int         PAGE_W     = 13,
   parameter int         BASE_OFF_W = 9,
   parameter int         ADDR_W     = 24,
   parameter logic [7:0] OPCODE     = 8'hD2,
   localparam int        N_KIND     = 3,
   localparam int        OFF_W      = BASE_OFF_W + N_KIND - 1
) (
   input  pg_kind_e            kind,
   input  logic [PAGE_W-1:0]   page,
   input  logic [OFF_W-1:0]    offset,
   output logic [ADDR_W+7:0]   hdr
);

   initial begin
      assert (PAGE_W + OFF_W <= ADDR_W)
         else $error("fgp_hdr_pack: page and offset do not fit the address");
   end

   logic [ADDR_W-1:0] cand [N_KIND];
   logic [ADDR_W-1:0] addr;

   for (genvar k = 0; k < N_KIND; k++) begin : g_layout
      assign cand[k] = ADDR_W'({page, offset[BASE_OFF_W+k-1:0]});
   end

   always_comb begin
      case (kind)
         PG_MID:   addr = cand[1];
         PG_LARGE: addr = cand[2];
         default:  addr = cand[0];
      endcase
   end

   assign hdr = {OPCODE, addr};

endmodule

// File: rtl/fgp_spi_shift.sv
module fgp_spi_shift #(
   parameter int  HALF_DIV = 2,
   parameter int  FRAME_W  = 32,
   parameter int  RX_W     = 8,
   localparam int CNT_W    = $clog2(FRAME_W + 1),
   localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [CNT_W-1:0]   nbits,
   input  logic [FRAME_W-1:0] tx,
   input  logic               miso,
   output logic               sck,
   output logic               cs_n,
   output logic               mosi,
   output logic [RX_W-1:0]    rx,
   output logic               done
);

   initial begin
      assert (HALF_DIV >= 1) else $error("fgp_spi_shift: HALF_DIV must be at least 1");
      assert (RX_W >= 2 && RX_W <= FRAME_W) else $error("fgp_spi_shift: bad RX_W");
   end

   logic               active;
   logic               tick;
   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   left;

   if (HALF_DIV == 1) begin : g_nodiv
      assign tick = active;
   end else begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            div_q <= '0;
         else if (!active || div_q == DIV_W'(HALF_DIV - 1))
            div_q <= '0;
         else
            div_q <= div_q + 1'b1;
      end
      assign tick = active && (div_q == DIV_W'(HALF_DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cs_n   <= 1'b1;
         sck    <= 1'b0;
         sh     <= '0;
         left   <= '0;
         rx     <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               cs_n   <= 1'b0;
               sh     <= tx;
               left   <= nbits;
            end
         end else if (tick) begin
            if (!sck) begin
               sck <= 1'b1;
               rx  <= {rx[RX_W-2:0], miso};
            end else begin
               sck <= 1'b0;
               if (left == CNT_W'(1)) begin
                  active <= 1'b0;
                  cs_n   <= 1'b1;
                  done   <= 1'b1;
               end else begin
                  sh   <= {sh[FRAME_W-2:0], 1'b0};
                  left <= left - 1'b1;
               end
            end
         end
      end
   end

   assign mosi = active & sh[FRAME_W-1];

   AST_SCK_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);                                                    // R12
   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && sck && $past(!cs_n && sck)) |-> $stable(mosi));          // R1

endmodule

// File: rtl/flash_geom_probe.sv
module flash_geom_probe
   import fgp_pkg::*;
#(
   parameter int         PAGE_W     = 13,
   parameter int         BASE_OFF_W = 9,
   parameter int         BASE_PAGE  = 264,
   parameter int         HALF_DIV   = 2,
   parameter logic [7:0] STAT_OPC   = 8'hD7,
   parameter logic [7:0] READ_OPC   = 8'hD2,
   localparam int        OFF_W      = BASE_OFF_W + 2,
   localparam int        ADDR_W     = 24,
   localparam int        FRAME_W    = ADDR_W + 8,
   localparam int        NB_W       = $clog2(FRAME_W + 1),
   localparam int        CODE_W     = 3,
   localparam int        CODE_LSB   = 3,
   localparam int        RDY_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_start,
   input  logic [PAGE_W-1:0] req_page,
   input  logic [OFF_W-1:0]  req_byte,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              ready,
   output logic [OFF_W-1:0]  page_bytes,
   output logic [CODE_W-1:0] density,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   initial begin
      assert (BASE_PAGE > (1 << (BASE_OFF_W - 1)) && BASE_PAGE <= (1 << BASE_OFF_W))
         else $error("flash_geom_probe: BASE_PAGE does not match BASE_OFF_W");
   end

   probe_state_e         state_q;
   logic                 ready_q;
   logic [CODE_W-1:0]    dens_q;
   pg_kind_e             kind_q;
   logic [FRAME_W-1:0]   hdr_q;
   logic                 done_q;
   logic                 err_q;

   logic                 eng_go;
   logic [NB_W-1:0]      eng_nbits;
   logic [FRAME_W-1:0]   eng_tx;
   logic [7:0]           eng_rx;
   logic                 eng_done;
   logic [CODE_W-1:0]    dec_code;
   pg_kind_e             dec_kind;
   logic [FRAME_W-1:0]   pack_hdr;
   logic [OFF_W-1:0]     pb;
   logic                 unused_stat;

   assign dec_code    = eng_rx[CODE_LSB +: CODE_W];
   assign unused_stat = ^{eng_rx[6], eng_rx[2:0]};
   assign pb          = OFF_W'(BASE_PAGE) << kind_q;

   fgp_density #(
      .CODE_W   (CODE_W),
      .MID_CODE (5),
      .TOP_CODE (7)
   ) i_density (
      .code (dec_code),
      .kind (dec_kind)
   );

   fgp_hdr_pack #(
      .PAGE_W     (PAGE_W),
      .BASE_OFF_W (BASE_OFF_W),
      .ADDR_W     (ADDR_W),
      .OPCODE     (READ_OPC)
   ) i_pack (
      .kind   (kind_q),
      .page   (req_page),
      .offset (req_byte),
      .hdr    (pack_hdr)
   );

   assign eng_go    = (state_q == S_PROBE) || (state_q == S_HDR);
   assign eng_nbits = (state_q == S_HDR) ? NB_W'(FRAME_W) : NB_W'(16);
   assign eng_tx    = (state_q == S_HDR) ? hdr_q : {STAT_OPC, {(FRAME_W-8){1'b0}}};

   fgp_spi_shift #(
      .HALF_DIV (HALF_DIV),
      .FRAME_W  (FRAME_W),
      .RX_W     (8)
   ) i_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (eng_go),
      .nbits (eng_nbits),
      .tx    (eng_tx),
      .miso  (spi_miso),
      .sck   (spi_sck),
      .cs_n  (spi_cs_n),
      .mosi  (spi_mosi),
      .rx    (eng_rx),
      .done  (eng_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_PROBE;
         ready_q <= 1'b0;
         dens_q  <= '0;
         kind_q  <= PG_SMALL;
         hdr_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            S_PROBE: state_q <= S_PROBE_WAIT;
            S_PROBE_WAIT: begin
               if (eng_done) begin
                  if (eng_rx[RDY_BIT]) begin
                     dens_q  <= dec_code;
                     kind_q  <= dec_kind;
                     ready_q <= 1'b1;
                     state_q <= S_IDLE;
                  end else begin
                     state_q <= S_PROBE;
                  end
               end
            end
            S_IDLE: begin
               if (req_start) begin
                  if (req_byte >= pb) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     hdr_q   <= pack_hdr;
                     state_q <= S_HDR;
                  end
               end
            end
            S_HDR: state_q <= S_HDR_WAIT;
            S_HDR_WAIT: begin
               if (eng_done) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            default: state_q <= S_PROBE;
         endcase
      end
   end

   assign busy       = (state_q != S_IDLE);
   assign done       = done_q;
   assign err        = err_q;
   assign ready      = ready_q;
   assign page_bytes = pb;
   assign density    = dens_q;

   AST_ERR_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> spi_cs_n);                                               // R10
   AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ready_q) |-> ready_q);                                       // R5
   AST_GEOM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_q && $past(ready_q)) |-> ($stable(dens_q) && $stable(pb))); // R5
   AST_NO_READ_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_q |-> (state_q == S_PROBE || state_q == S_PROBE_WAIT));     // R11
   AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == S_IDLE));                                   // R6

endmodule

// File: tb/test_flash_geom_probe.sv
module test_flash_geom_probe;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic [12:0] req_page = '0;
   logic [10:0] req_byte = '0;
   logic        busy, done, err, ready;
   logic [10:0] page_bytes;
   logic [2:0]  density;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   flash_geom_probe i_flash_geom_probe (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_page(req_page),
      .req_byte(req_byte), .busy(busy), .done(done), .err(err), .ready(ready),
      .page_bytes(page_bytes), .density(density), .spi_sck(spi_sck),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // flash model and monitor, sampled on the falling clock edge
   logic [7:0]  stat_val = 8'hBC;
   int          busy_left = 0;
   logic [7:0]  cur_stat = '0;
   logic        prev_sck = 1'b0, prev_cs = 1'b1;
   int          bitcnt = 0;
   logic [31:0] cap = '0;
   int          nframes = 0, last_bits = 0, sck_bad = 0, ndone = 0, nerr = 0;
   logic [31:0] last_frame = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_cs_n && spi_sck) sck_bad++;
         if (prev_cs && !spi_cs_n) begin
            bitcnt = 0;
            cap = '0;
            if (busy_left > 0) begin
               cur_stat = stat_val & 8'h7F;
               busy_left--;
            end else begin
               cur_stat = stat_val;
            end
         end
         if (!spi_cs_n && !prev_sck && spi_sck) begin
            cap = {cap[30:0], spi_mosi};
            bitcnt++;
         end
         if (!spi_cs_n && prev_sck && !spi_sck && bitcnt >= 8 && bitcnt < 16)
            spi_miso = cur_stat[15-bitcnt];
         if (!prev_cs && spi_cs_n) begin
            nframes++;
            last_bits = bitcnt;
            last_frame = cap;
         end
         if (done) ndone++;
         if (done && err) nerr++;
      end
      prev_sck = spi_sck;
      prev_cs  = spi_cs_n;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary_and_end();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary_and_end();
   end

   task automatic wait_ready();
      for (int i = 0; i < 3000 && !ready; i++) @(negedge clk);
   endtask

   task automatic do_reset(input logic [7:0] sv, input int nbusy);
      @(negedge clk);
      rst_n = 1'b0;
      stat_val = sv;
      busy_left = nbusy;
      repeat (3) @(negedge clk);
      nframes = 0; ndone = 0; nerr = 0; sck_bad = 0;
      check(busy && !ready && !done && spi_cs_n && !spi_sck, "R1", "reset state",
            {busy, ready, done, spi_cs_n, spi_sck}, 5'b10010);
      rst_n = 1'b1;
   endtask

   // R1 R2 R3: detection for one status byte
   task automatic t_detect(input logic [7:0] sv, input int exp_code, input int exp_pb);
      do_reset(sv, 0);
      wait_ready();
      check(ready, "R1", "ready after probe", ready, 1);
      check(nframes == 1 && last_bits == 16 && last_frame[15:8] == 8'hD7, "R1",
            "status frame", {last_bits, last_frame[15:8]}, {16, 8'hD7});
      check(density == exp_code, "R2", "density code", density, exp_code);
      check(page_bytes == exp_pb, "R3", "page size", page_bytes, exp_pb);
   endtask

   function automatic logic [31:0] exp_hdr(input int sh, input int page, input int byt);
      logic [31:0] a;
      a = page * (512 << sh) + byt;
      return {8'hD2, a[23:0]};
   endfunction

   task automatic pulse_req(input int page, input int byt);
      @(negedge clk);
      req_page = 13'(page);
      req_byte = 11'(byt);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
   endtask

   // R6 with R7/R8/R9 layout
   task automatic t_read(input string req, input int sh, input int page, input int byt);
      int f0, d0;
      logic [31:0] e;
      f0 = nframes; d0 = ndone;
      e = exp_hdr(sh, page, byt);
      pulse_req(page, byt);
      check(busy, "R6", "busy after accept", busy, 1);
      for (int i = 0; i < 500 && ndone == d0; i++) @(negedge clk);
      check(ndone == d0 + 1 && !err, "R6", "done without err", {ndone - d0, err}, 2);
      check(nframes == f0 + 1 && last_bits == 32, "R6", "one 32-clock frame",
            last_bits, 32);
      check(last_frame == e, req, "header", last_frame, e);
      check(spi_cs_n && sck_bad == 0, "R12", "select released, clock parked",
            sck_bad, 0);
   endtask

   // R10 out-of-range offset
   task automatic t_reject(input int page, input int byt);
      int f0, d0, e0;
      f0 = nframes; d0 = ndone; e0 = nerr;
      pulse_req(page, byt);
      for (int i = 0; i < 20 && ndone == d0; i++) @(negedge clk);
      check(ndone == d0 + 1 && nerr == e0 + 1, "R10", "done with err",
            nerr - e0, 1);
      check(nframes == f0, "R10", "no frame issued", nframes - f0, 0);
   endtask

   // R4 R11 busy polling with a request arriving during detection
   task automatic t_busy_poll();
      do_reset(8'hAC, 3);
      pulse_req(5, 3);
      check(!ready, "R4", "not ready while device busy", ready, 0);
      wait_ready();
      check(ready && nframes == 4 && last_bits == 16, "R4", "status frames polled",
            nframes, 4);
      repeat (200) @(negedge clk);
      check(ndone == 0, "R11", "early request dropped", ndone, 0);
      check(nframes == 4, "R11", "no read frame from early request", nframes, 4);
      check(page_bytes == 528 && density == 5, "R5", "geometry held",
            page_bytes, 528);
   endtask

   initial begin
      t_detect(8'h9C, 3, 264);
      t_detect(8'hA4, 4, 264);
      t_detect(8'hAC, 5, 528);
      t_detect(8'hB4, 6, 528);
      t_detect(8'hBC, 7, 1056);
      t_detect(8'h84, 0, 264);

      t_detect(8'h9C, 3, 264);
      t_read("R7", 0, 13'h1ABC, 263);
      t_read("R7", 0, 13'h0123, 0);
      t_reject(7, 264);
      t_read("R7", 0, 13'h1FFF, 257);

      t_detect(8'hB4, 6, 528);
      t_read("R8", 1, 13'h0F0F, 527);
      t_reject(3, 528);
      t_read("R8", 1, 13'h1555, 300);

      t_detect(8'hBC, 7, 1056);
      t_read("R9", 2, 13'h1FFF, 1055);
      t_read("R9", 2, 13'h0A5A, 13'h3C5);
      t_reject(1, 1056);
      t_reject(1, 2047);
      check(density == 7 && page_bytes == 1056 && ready, "R5", "geometry stable after reads",
            page_bytes, 1056);

      t_busy_poll();
      summary_and_end();
   end

endmodule